// File: doc/BRIEF.md
# Programmable Countdown Timer with Interrupt

A single-channel down-counter behind a simple 32-bit register bus. The bus uses word-aligned byte offsets and single-cycle read and write strobes. Software writes a 64-bit reload value as two 32-bit words. It then writes a control word that starts the count, picks the mode and gates the interrupt. When the count reaches zero, the timer sets a sticky expiry flag. If the interrupt is unmasked, the timer also raises `irq_o`. After that it either reloads and keeps going (periodic) or halts (single shot).

The bus and the count share one clock. Read data is combinational while `rd_en_i` is high and is zero otherwise. Writes take effect on the clock edge at which `wr_en_i` is sampled high.

Top module: `cdtimer_top`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is 0.
- R2: Byte offset 0x00 holds reload bits [31:0] and 0x04 holds bits [63:32]. Both read back as written. Offset 0x10 is control: bit0 run, bit1 single-shot select, bit2 interrupt enable. It reads back bits [2:0] with the upper bits 0. Offset 0x18 reads the expiry flag in bit0.
- R3: Reads of any other word offset return 0, and writes to those offsets change no register.
- R4: A control write that moves bit0 from 0 to 1 loads the reload value N. The first expiry is on the (N+1)th clock edge after that write's edge.
- R5: With bit1 = 0, the counter reloads at each expiry, so expiries repeat every N+1 clocks.
- R6: With bit1 = 1, the counter expires once and halts. It expires again only after bit0 is written to 0 and then back to 1.
- R7: Writing 0 to the control word halts the counter, and no further expiry occurs.
- R8: `irq_o` is a register equal to the expiry flag AND control bit2. With bit2 = 0, expiry sets the flag but `irq_o` stays 0.
- R9: Writing 1 to bit0 of offset 0x18 clears the flag. Writing 0 there leaves it unchanged.
- R10: An expiry on the same edge as a clear leaves the flag set.
- R11: A reload-value write made while the counter runs does not alter the count in progress. It is used from the next reload onward.
- R12: The reload value is the full 64-bit {bits[63:32], bits[31:0]}, so a nonzero upper word lengthens the interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and count clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Single-cycle write strobe |
| rd_en_i | input | 1 | Read strobe; read data valid while high |
| addr_i | input | ADDR_W | Byte offset (bits [1:0] ignored) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench measures interval lengths in whole clocks. A counter that is off by one at start-up or at reload, or one that reloads the live value in the middle of a count, shows up as a wrong cycle count.

It lets a periodic count of zero expire on every edge while a clear is issued. A design in which the clear takes priority would lose that event and read the flag back as 0.

It re-arms a single-shot count and watches a long idle window after each expiry. A design that reloads in single-shot mode, or that ignores an upper reload word, fires inside that window.

Toggling the mask while the flag is held checks that the interrupt follows the mask and that the flag does not.

// File: rtl/cdtimer_pkg.sv
package cdtimer_pkg;
  localparam int unsigned BUS_W    = 32;
  localparam int unsigned CTRL_OFF = 32'h10;
  localparam int unsigned STAT_OFF = 32'h18;

  typedef struct packed {
    logic unmask;   // bit2
    logic oneshot;  // bit1
    logic en;       // bit0
  } ctrl_t;
endpackage

// File: rtl/cdtimer_regs.sv
module cdtimer_regs
  import cdtimer_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic              status_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic [CNT_W-1:0]  load_o,
  output ctrl_t             ctrl_q_o,
  output ctrl_t             ctrl_d_o,
  output logic              start_o,
  output logic              clr_o
);
  localparam int unsigned WIDX_W     = ADDR_W - 2;
  localparam int unsigned LOAD_WORDS = CNT_W / BUS_W;
  localparam logic [WIDX_W-1:0] CTRL_IDX = WIDX_W'(CTRL_OFF >> 2);
  localparam logic [WIDX_W-1:0] STAT_IDX = WIDX_W'(STAT_OFF >> 2);

  logic [WIDX_W-1:0] widx;
  logic [BUS_W-1:0]  load_w [LOAD_WORDS];
  logic              hit_load, hit_ctrl, hit_stat;
  ctrl_t             ctrl_q;

  assign widx     = addr_i[ADDR_W-1:2];
  assign hit_load = (widx < WIDX_W'(LOAD_WORDS));
  assign hit_ctrl = (widx == CTRL_IDX);
  assign hit_stat = (widx == STAT_IDX);

  for (genvar k = 0; k < LOAD_WORDS; k++) begin : g_load
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) load_w[k] <= '0;
      else if (wr_en_i && widx == WIDX_W'(k)) load_w[k] <= wdata_i;
    end
    assign load_o[k*BUS_W +: BUS_W] = load_w[k];
  end

  assign ctrl_d_o = (wr_en_i && hit_ctrl) ? ctrl_t'(wdata_i[2:0]) : ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d_o;
  end

  assign ctrl_q_o = ctrl_q;
  assign start_o  = ctrl_d_o.en && !ctrl_q.en;
  assign clr_o    = wr_en_i && hit_stat && wdata_i[0];

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      for (int k = 0; k < LOAD_WORDS; k++)
        if (widx == WIDX_W'(k)) rdata_o = load_w[k];
      if (hit_ctrl) rdata_o = {{(BUS_W-3){1'b0}}, ctrl_q};
      if (hit_stat) rdata_o = {{(BUS_W-1){1'b0}}, status_i};
    end
  end

  p_unmapped_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !hit_load && !hit_ctrl && !hit_stat) |-> (rdata_o == '0));
  p_unmapped_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !hit_load && !hit_ctrl && !hit_stat) |=> ($stable(load_o) && $stable(ctrl_q)));
endmodule

// File: rtl/cdtimer_counter.sv
module cdtimer_counter #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] load_i,
  input  logic             start_i,
  input  logic             en_nxt_i,
  input  logic             oneshot_i,
  output logic             running_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             running_q;
  logic             at_zero;

  assign at_zero   = (cnt_q == '0);
  assign expire_o  = running_q && at_zero;
  assign running_o = running_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      running_q <= 1'b0;
    end else if (start_i) begin
      cnt_q     <= load_i;
      running_q <= 1'b1;
    end else if (!en_nxt_i) begin
      running_q <= 1'b0;
    end else if (running_q) begin
      if (!at_zero)       cnt_q     <= cnt_q - CNT_W'(1);
      else if (oneshot_i) running_q <= 1'b0;
      else                cnt_q     <= load_i;  // periodic reload
    end
  end

  p_start_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (running_q && cnt_q == $past(load_i)));
  p_decrement_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_q && !at_zero && en_nxt_i && !start_i) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  p_reload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && !oneshot_i && en_nxt_i && !start_i) |=> (running_q && cnt_q == $past(load_i)));
  p_oneshot_halt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && oneshot_i && !start_i) |=> !running_q);
endmodule

// File: rtl/cdtimer_irq.sv
module cdtimer_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic clr_i,
  input  logic unmask_nxt_i,
  output logic status_o,
  output logic irq_o
);
  logic status_q, status_d, irq_q;

  // set has priority over clear
  assign status_d = expire_i || (status_q && !clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      irq_q    <= status_d && unmask_nxt_i;
    end
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;

  p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> status_q);
  p_w1c_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !expire_i) |=> !status_q);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q && !clr_i) |=> status_q);
endmodule

// File: rtl/cdtimer_top.sv
module cdtimer_top
  import cdtimer_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] load;
  ctrl_t            ctrl_q, ctrl_d;
  logic             start, clr, status, running, expire;

  cdtimer_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .status_i (status),
    .rdata_o  (rdata_o),
    .load_o   (load),
    .ctrl_q_o (ctrl_q),
    .ctrl_d_o (ctrl_d),
    .start_o  (start),
    .clr_o    (clr)
  );

  cdtimer_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .start_i   (start),
    .en_nxt_i  (ctrl_d.en),
    .oneshot_i (ctrl_q.oneshot),
    .running_o (running),
    .expire_o  (expire)
  );

  cdtimer_irq u_irq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .expire_i     (expire),
    .clr_i        (clr),
    .unmask_nxt_i (ctrl_d.unmask),
    .status_o     (status),
    .irq_o        (irq_o)
  );

  p_halted_when_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.en |-> !running);
  p_irq_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (status && ctrl_q.unmask));
endmodule

// File: tb/cdtimer_top_tb_top.sv
module cdtimer_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  cdtimer_top #(.ADDR_W(8), .CNT_W(64)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  localparam logic [7:0] A_LO = 8'h00, A_HI = 8'h04, A_CTRL = 8'h10, A_STAT = 8'h18;

  function automatic bit is_mapped(logic [7:0] a);
    return a[7:2] == 6'd0 || a[7:2] == 6'd1 || a[7:2] == 6'd4 || a[7:2] == 6'd6;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic run_until(int limit, output int n);
    n = 0;
    while (!irq && n < limit) begin @(negedge clk); n++; end
  endtask

  task automatic quiesce();
    wr(A_CTRL, 32'h0);
    wr(A_STAT, 32'h1);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      report();
    end
  end

  initial begin
    logic [31:0] d, v;
    int n, n2;
    bit seen;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", irq, 0);
    foreach (d[i]) ; // no-op keeps d declared use simple
    rd(A_LO, d);   chk("R1 lo", d, 0);
    rd(A_HI, d);   chk("R1 hi", d, 0);
    rd(A_CTRL, d); chk("R1 ctrl", d, 0);
    rd(A_STAT, d); chk("R1 stat", d, 0);

    // R2 readback, random data
    for (int i = 0; i < 12; i++) begin
      v = $urandom; wr(A_LO, v); rd(A_LO, d); chk("R2 lo", d, v);
      v = $urandom; wr(A_HI, v); rd(A_HI, d); chk("R2 hi", d, v);
      v = $urandom & 32'hFFFF_FFFE; wr(A_CTRL, v); rd(A_CTRL, d); chk("R2 ctrl", d, v & 32'h7);
    end
    quiesce();

    // R3 unmapped offsets
    wr(A_LO, 32'h1234_5678);
    for (int i = 0; i < 10; i++) begin
      logic [7:0] a;
      do a = 8'($urandom) & 8'hFC; while (is_mapped(a));
      wr(a, $urandom | 32'h1);
      rd(a, d); chk("R3 unmapped read", d, 0);
    end
    rd(A_LO, d);   chk("R3 lo untouched", d, 32'h1234_5678);
    rd(A_CTRL, d); chk("R3 ctrl untouched", d, 0);
    chk("R3 no irq", irq, 0);

    // R4/R5 periodic intervals, directed then random N
    for (int i = 0; i < 7; i++) begin
      int nv;
      nv = (i == 0) ? 1 : 1 + int'($urandom % 30);
      quiesce();
      wr(A_HI, 0); wr(A_LO, nv);
      wr(A_CTRL, 32'h5);
      run_until(200, n);  chk("R4 first interval", n, nv + 1);
      wr(A_STAT, 32'h1);
      run_until(200, n2); chk("R5 reload interval", n2, nv);
    end
    quiesce();

    // R6 single shot
    wr(A_LO, 5);
    wr(A_CTRL, 32'h7);
    run_until(100, n); chk("R6 fires", n, 6);
    wr(A_STAT, 32'h1);
    run_until(60, n);  chk("R6 no second expiry", n, 60);
    wr(A_CTRL, 32'h0); wr(A_CTRL, 32'h7);
    run_until(100, n); chk("R6 re-armed", n, 6);
    quiesce();

    // R7 stop mid-count
    wr(A_LO, 10);
    wr(A_CTRL, 32'h5);
    repeat (4) @(negedge clk);
    wr(A_CTRL, 32'h0);
    run_until(60, n);  chk("R7 halted", n, 60);
    rd(A_STAT, d);     chk("R7 flag clear", d, 0);

    // R8 mask gating
    wr(A_LO, 3);
    wr(A_CTRL, 32'h1);
    seen = 1'b0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); if (irq) seen = 1'b1; end
    chk("R8 masked irq low", seen, 0);
    rd(A_STAT, d);     chk("R8 masked flag set", d, 1);
    wr(A_CTRL, 32'h5); chk("R8 unmask raises irq", irq, 1);
    wr(A_CTRL, 32'h1); chk("R8 mask drops irq", irq, 0);
    wr(A_CTRL, 32'h0);

    // R9 write-1-to-clear
    rd(A_STAT, d);    chk("R9 flag held", d, 1);
    wr(A_STAT, 32'h0);
    rd(A_STAT, d);    chk("R9 write 0 ignored", d, 1);
    wr(A_STAT, 32'h1);
    rd(A_STAT, d);    chk("R9 write 1 clears", d, 0);

    // R10 set beats clear (expiry every edge)
    wr(A_LO, 0);
    wr(A_CTRL, 32'h5);
    repeat (3) @(negedge clk);
    wr(A_STAT, 32'h1);
    chk("R10 irq stays", irq, 1);
    rd(A_STAT, d);    chk("R10 flag stays", d, 1);
    quiesce();
    rd(A_STAT, d);    chk("R10 cleared when halted", d, 0);

    // R11 reload write during a run
    wr(A_LO, 4);
    wr(A_CTRL, 32'h5);
    run_until(100, n); chk("R11 first", n, 5);
    wr(A_LO, 9);
    wr(A_STAT, 32'h1);
    run_until(100, n); chk("R11 old value kept", n, 3);
    wr(A_STAT, 32'h1);
    run_until(100, n); chk("R11 new value at reload", n, 9);
    quiesce();

    // R12 upper word counts
    wr(A_LO, 0); wr(A_HI, 1);
    wr(A_CTRL, 32'h5);
    run_until(300, n); chk("R12 long interval", n, 300);
    rd(A_HI, d);       chk("R12 hi kept", d, 1);
    quiesce();

    done = 1'b1;
    report();
  end
endmodule